// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output channel of a general-purpose timer. A small counter runs up or down between zero and a programmable reload value. On every clock the count is compared with a compare value, and one of eight selectable behaviours turns that comparison into an active-high reference waveform. The behaviours are: hold, set on match, clear on match, toggle on match, force low, force high, and two pulse-width flavours that follow the count direction.

The reference goes out unchanged on a trigger output so that other timers can use it. It also passes through an XOR with a polarity bit and then through an enable gate to form the pin value and its output-enable flag. New reload and compare values are taken from the input ports only when the counter wraps, so a running period always uses one consistent pair. All configuration arrives on plain input ports.

Top module: `tmr_oc_chan`

## Requirements
- R1: When `cnt_en` is high, the counter advances one step per clock. Counting up (`dir_down`=0), it wraps to 0 on the clock where the count is at or above the active reload value, and increments otherwise. Counting down (`dir_down`=1), it loads `reload_in` on the clock where the count is 0, and decrements otherwise. When `cnt_en` is low, the count holds.
- R2: With `mode_in`=000 (frozen), the reference keeps its value whatever the count and compare values are.
- R3: With `mode_in`=001, the reference is set to 1 on a match. With 010, it is cleared to 0 on a match. With 011, it is inverted on a match. A match is a clock where `cnt_en` is high and the count equals the active compare value. A counter stopped on the compare value causes no further change.
- R4: With `mode_in`=100, the reference becomes 0 on the next clock. With 101, it becomes 1. Neither depends on the count.
- R5: With `mode_in`=110: counting up, the next reference is 1 when count < compare and 0 otherwise; counting down, it is 0 when count > compare and 1 otherwise.
- R6: With `mode_in`=111, the next reference is the inverse of the R5 value for the same count, compare value and direction.
- R7: One clock after `oe_in` is sampled high, `pin_oe_o` is 1 and `pin_o` equals `ref_o` XOR the registered `pol_in`. Polarity 0 gives an active-high pin and polarity 1 gives an active-low pin.
- R8: One clock after `oe_in` is sampled low, `pin_oe_o` is 0 and `pin_o` is 0, whatever the reference and polarity are.
- R9: `trig_o` always equals `ref_o`, which is the reference before the polarity stage.
- R10: `reload_in` and `cmp_in` become the active reload and compare values only on a wrap or reload clock (see R1). Changes between wraps do not affect the running period.
- R11: While `rst_n` is low, the count, the active reload value, the active compare value, `ref_o`, `trig_o`, `pin_o` and `pin_oe_o` are all 0, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| dir_down | input | 1 | Count direction, 1 = down |
| reload_in | input | CW | Preload reload value |
| cmp_in | input | CW | Preload compare value |
| mode_in | input | 3 | Compare behaviour select |
| pol_in | input | 1 | Output polarity, 1 = active low |
| oe_in | input | 1 | Channel output enable |
| ref_o | output | 1 | Active-high reference waveform |
| trig_o | output | 1 | Reference copy for other timers |
| pin_o | output | 1 | Channel pin value |
| pin_oe_o | output | 1 | Channel pin drive enable |

## Verification
The hardest situation to reach is a toggle-on-match channel with its counter stopped exactly on the compare value. The stimulus gets there by running the counter with the enable held high until the bench's own count model equals the compare value, and then dropping the enable for several clocks. A second hard case is a compare or reload change in the middle of a period. To test it, a pulse-width mode runs, new values are presented partway through, and the bench checks that the waveform keeps the old duty until the next wrap. Around these cases, a sweep covers every mode, both directions and both polarities. For each combination it uses several reload/compare pairs, including a compare value above the reload value, and a random count enable.

// File: rtl/tmr_oc_chan.sv
module tmr_oc_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          dir_down,
  input  logic [CW-1:0] reload_in,
  input  logic [CW-1:0] cmp_in,
  input  logic [2:0]    mode_in,
  input  logic          pol_in,
  input  logic          oe_in,
  output logic          ref_o,
  output logic          trig_o,
  output logic          pin_o,
  output logic          pin_oe_o
);
  localparam logic [2:0] M_FROZEN = 3'd0;
  localparam logic [2:0] M_SET    = 3'd1;
  localparam logic [2:0] M_CLR    = 3'd2;
  localparam logic [2:0] M_TOG    = 3'd3;
  localparam logic [2:0] M_LOW    = 3'd4;
  localparam logic [2:0] M_HIGH   = 3'd5;
  localparam logic [2:0] M_PWM1   = 3'd6;
  localparam logic [2:0] M_PWM2   = 3'd7;
  localparam logic [CW-1:0] ONE   = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, rel_q, cmp_q;
  logic          ref_q, ref_d, pol_q, oe_q;

  wire at_top  = cnt_q >= rel_q;
  wire at_zero = cnt_q == '0;
  wire wrap    = cnt_en && (dir_down ? at_zero : at_top);
  wire match   = cnt_en && (cnt_q == cmp_q);
  wire pwm1    = dir_down ? !(cnt_q > cmp_q) : (cnt_q < cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      if (dir_down) cnt_q <= at_zero ? reload_in : cnt_q - ONE;
      else          cnt_q <= at_top ? '0 : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= '0;
      cmp_q <= '0;
    end else if (wrap) begin
      rel_q <= reload_in;
      cmp_q <= cmp_in;
    end
  end

  always_comb begin
    ref_d = ref_q;
    case (mode_in)
      M_FROZEN: ref_d = ref_q;
      M_SET:    if (match) ref_d = 1'b1;
      M_CLR:    if (match) ref_d = 1'b0;
      M_TOG:    if (match) ref_d = !ref_q;
      M_LOW:    ref_d = 1'b0;
      M_HIGH:   ref_d = 1'b1;
      M_PWM1:   ref_d = pwm1;
      M_PWM2:   ref_d = !pwm1;
      default:  ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      pol_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      ref_q <= ref_d;
      pol_q <= pol_in;
      oe_q  <= oe_in;
    end
  end

  assign ref_o    = ref_q;
  assign trig_o   = ref_q;
  assign pin_oe_o = oe_q;
  assign pin_o    = oe_q & (ref_q ^ pol_q);
endmodule

// File: rtl/tmr_oc_chan_chk.sv
module tmr_oc_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_en,
  input logic [2:0] mode_in,
  input logic       pol_in,
  input logic       ref_o,
  input logic       trig_o,
  input logic       pin_o,
  input logic       pin_oe_o
);
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 3'd0) |=> $stable(ref_o)); // R2
  AST_NO_MATCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && (mode_in == 3'd1 || mode_in == 3'd2 || mode_in == 3'd3)) |=> $stable(ref_o)); // R3
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 3'd4) |=> !ref_o); // R4
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_in == 3'd5) |=> ref_o); // R4
  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe_o |-> (pin_o == (ref_o ^ $past(pol_in)))); // R7
  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe_o |-> !pin_o); // R8
  AST_TRIG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_o) |-> $rose(trig_o)); // R9
endmodule

bind tmr_oc_chan tmr_oc_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_in(mode_in), .pol_in(pol_in),
  .ref_o(ref_o), .trig_o(trig_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
);

// File: tb/tmr_oc_chan_tb_top.sv
`timescale 1ns/1ps
module tmr_oc_chan_tb_top;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, dir_down = 1'b0, pol_in = 1'b0, oe_in = 1'b0;
  logic [CW-1:0] reload_in = '0, cmp_in = '0;
  logic [2:0] mode_in = 3'd0;
  logic ref_o, trig_o, pin_o, pin_oe_o;

  always #4 clk = ~clk;

  tmr_oc_chan #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_down(dir_down),
    .reload_in(reload_in), .cmp_in(cmp_in), .mode_in(mode_in),
    .pol_in(pol_in), .oe_in(oe_in), .ref_o(ref_o), .trig_o(trig_o),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_rel = 0, m_cmp = 0;
  logic m_ref = 1'b0, m_pol = 1'b0, m_oe = 1'b0;
  string extra = "";

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic match, p1;
    string tag;
    @(posedge clk);
    match = cnt_en && (m_cnt == m_cmp);
    p1 = dir_down ? !(m_cnt > m_cmp) : (m_cnt < m_cmp);
    case (mode_in)
      3'd1: begin if (match) m_ref = 1'b1; tag = "R3"; end
      3'd2: begin if (match) m_ref = 1'b0; tag = "R3"; end
      3'd3: begin if (match) m_ref = !m_ref; tag = "R3"; end
      3'd4: begin m_ref = 1'b0; tag = "R4"; end
      3'd5: begin m_ref = 1'b1; tag = "R4"; end
      3'd6: begin m_ref = p1; tag = "R5 R1"; end
      3'd7: begin m_ref = !p1; tag = "R6 R1"; end
      default: tag = "R2";
    endcase
    if (cnt_en) begin
      if (dir_down) begin
        if (m_cnt == 0) begin m_cnt = int'(reload_in); m_rel = int'(reload_in); m_cmp = int'(cmp_in); end
        else m_cnt = m_cnt - 1;
      end else begin
        if (m_cnt >= m_rel) begin m_cnt = 0; m_rel = int'(reload_in); m_cmp = int'(cmp_in); end
        else m_cnt = m_cnt + 1;
      end
    end
    m_pol = pol_in;
    m_oe = oe_in;
    @(negedge clk);
    check({tag, " ", extra}, ref_o, m_ref);
    check("R9", trig_o, m_ref);
    if (m_oe) begin
      check("R7", pin_oe_o, 1'b1);
      check("R7", pin_o, m_ref ^ m_pol);
    end else begin
      check("R8", pin_oe_o, 1'b0);
      check("R8", pin_o, 1'b0);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int rels[4];
    int cmps[4];
    rels = '{9, 5, 15, 0};
    cmps = '{0, 3, 9, 12};
    mode_in = 3'd5; oe_in = 1'b1; pol_in = 1'b1; cnt_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", ref_o, 1'b0);
    check("R11", trig_o, 1'b0);
    check("R11", pin_o, 1'b0);
    check("R11", pin_oe_o, 1'b0);
    mode_in = 3'd0; oe_in = 1'b0; pol_in = 1'b0; cnt_en = 1'b0;
    rst_n = 1'b1;
    step();

    for (int d = 0; d < 2; d++)
      for (int md = 0; md < 8; md++)
        for (int p = 0; p < 2; p++)
          for (int k = 0; k < 4; k++) begin
            dir_down = d[0];
            mode_in = md[2:0];
            pol_in = p[0];
            oe_in = (k != 3);
            reload_in = rels[k][CW-1:0];
            cmp_in = cmps[(k + md) % 4][CW-1:0];
            for (int i = 0; i < 24; i++) begin
              cnt_en = ($urandom % 4) != 0;
              step();
            end
          end

    // Toggle mode with the counter parked on the compare value (R3)
    dir_down = 1'b0; oe_in = 1'b1; pol_in = 1'b0; cnt_en = 1'b1;
    reload_in = 4'd9; cmp_in = 4'd4; mode_in = 3'd0;
    for (int i = 0; i < 30; i++) step();
    mode_in = 3'd3;
    for (int i = 0; i < 40 && m_cnt != m_cmp; i++) step();
    extra = "R3 stopped";
    cnt_en = 1'b0;
    for (int i = 0; i < 6; i++) step();
    cnt_en = 1'b1;
    for (int i = 0; i < 12; i++) step();

    // Compare/reload changes mid-period take effect only at wrap (R10)
    extra = "R10";
    mode_in = 3'd6; reload_in = 4'd9; cmp_in = 4'd5;
    for (int i = 0; i < 25; i++) step();
    for (int i = 0; i < 3; i++) step();
    cmp_in = 4'd2; reload_in = 4'd3;
    for (int i = 0; i < 20; i++) step();
    dir_down = 1'b1; cmp_in = 4'd7; reload_in = 4'd12;
    for (int i = 0; i < 30; i++) step();
    extra = "";

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule